// File: doc/BRIEF.md
# Serial Sampling-Converter Host Controller

This block is the master of a three-wire serial link to a sampling converter: it drives an active-low select and a serial clock, and it shifts in the converter's data line. A pulse on `start` runs a complete 16-clock frame. The last 12 bits received, most significant first, are returned on `sample` together with a one-cycle `sample_valid` strobe. A pulse on `shutdown_req` runs a short frame that releases the select inside the converter's sleep window, which puts the converter into its low-power state. The `abort` input cuts any frame short.

The controller keeps its own copy of the converter's power state on `awake`. This copy follows how many serial-clock falling edges had occurred before the select was raised. A frame that starts while the converter sleeps wakes it up, and the data from that frame is thrown away. After every release of the select the controller waits a parameterised quiet time before it starts another frame. Each serial-clock phase lasts `CLK_DIV` system clocks.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, `cs_n` and `sclk` are 1, `busy` and `sample_valid` are 0, and `awake` is 0, which means the converter is assumed to be asleep.
- R2: When the block is idle, `start` drives `cs_n` low and runs a frame of exactly 16 `sclk` falling edges and 16 rising edges before `cs_n` rises again. `sclk` is 1 whenever `cs_n` is 1.
- R3: `miso` is sampled on every rising edge of `sclk`. At the end of a full frame, `sample` holds the last 12 of the 16 received bits, with the first of those 12 in bit 11.
- R4: `sample_valid` is a one-cycle pulse that appears together with the rise of `cs_n` at the end of a full read frame. It is asserted only if `awake` was 1 when that frame began.
- R5: A full read frame that starts with `awake` at 0 gives no `sample_valid`, and it leaves `awake` at 1.
- R6: When the block is idle, `shutdown_req` runs a frame that raises `cs_n` while `sclk` is low after the 3rd falling edge. This frame clears `awake` and gives no `sample_valid`.
- R7: If `start` and `shutdown_req` arrive in the same idle cycle, the shutdown frame is run.
- R8: `abort` during a frame raises `cs_n` on the next clock edge and gives no `sample_valid`. The falling-edge count up to that point sets `awake` as follows: with fewer than 2 edges it is unchanged, with 2 to 9 edges it becomes 0, and with 10 to 15 edges it becomes 1.
- R9: After every rise of `cs_n`, `cs_n` stays high for at least `QUIET_CYC` clocks. `busy` is 1 from the cycle `cs_n` falls until the quiet time ends.
- R10: `start` and `shutdown_req` have no effect while `busy` is 1. No frame follows from them once the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read frame (taken only when idle) |
| shutdown_req | input | 1 | Request a power-down frame (taken only when idle) |
| abort | input | 1 | Cut the current frame short |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idles high |
| sample | output | 12 | Last valid conversion result |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| busy | output | 1 | Frame or quiet time in progress |
| awake | output | 1 | Controller's copy of the converter power state |

## Verification
Several rules are checked by assertions on every cycle. `sclk` must idle high under a released select. `busy` must cover every selected cycle. A strobe may appear only when the select rises after a full frame begun awake. The quiet gap is measured before each new select. The power-state updates are checked against the falling-edge count at release. Other behaviour can only be shown by the bench's scenarios against a behavioural converter model. These are the bit order and alignment of the captured word, the exact edge counts of read and shutdown frames, the priority between simultaneous commands, the discard on wake-up, and the fact that requests made while busy are dropped rather than queued.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } host_state_e;

  typedef enum logic {
    CMD_READ,
    CMD_SLEEP
  } host_cmd_e;

endpackage

// File: rtl/adc_host_tick.sv
// Phase counter: while enabled, counts 0..LIMIT-1 and flags the last count.
module adc_host_tick #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic done
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!en)      cnt_d = '0;
    else if (done) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/adc_host_shift.sv
// Capture shift register, most significant bit first.
module adc_host_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] dout
);
  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign dout = sh_q;
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int QUIET_CYC  = 5,
  parameter int FRAME_BITS = 16,
  parameter int DATA_BITS  = 12,
  parameter int SLEEP_EDGE = 3,
  parameter int SHDN_FIRST = 2,
  parameter int SHDN_LAST  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 shutdown_req,
  input  logic                 abort,
  input  logic                 miso,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] sample,
  output logic                 sample_valid,
  output logic                 busy,
  output logic                 awake
);
  localparam int EW = $clog2(FRAME_BITS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  host_state_e          state_q, state_d;
  host_cmd_e            cmd_q, cmd_d;
  logic [EW-1:0]        fcnt_q, fcnt_d;
  logic                 cs_n_q, cs_n_d, sclk_q, sclk_d;
  logic                 awake_q, awake_d, woke_q, woke_d;
  logic                 valid_q, valid_d;
  logic [DATA_BITS-1:0] sample_q, sample_d, cap;
  logic                 div_en, div_done, quiet_en, quiet_done, shift_en;

  assign div_en   = (state_q == ST_LEAD) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign quiet_en = (state_q == ST_QUIET);

  adc_host_tick #(.LIMIT(CLK_DIV)) u_div (
    .clk(clk), .rst_n(rst_i_n), .en(div_en), .done(div_done));

  adc_host_tick #(.LIMIT(QUIET_CYC)) u_quiet (
    .clk(clk), .rst_n(rst_i_n), .en(quiet_en), .done(quiet_done));

  assign shift_en = (state_q == ST_LOW) && (state_d == ST_HIGH);

  adc_host_shift #(.W(DATA_BITS)) u_cap (
    .clk(clk), .rst_n(rst_i_n), .shift_en(shift_en), .din(miso), .dout(cap));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cmd_d    = cmd_q;
    fcnt_d   = fcnt_q;
    cs_n_d   = cs_n_q;
    sclk_d   = sclk_q;
    awake_d  = awake_q;
    woke_d   = woke_q;
    sample_d = sample_q;
    valid_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start || shutdown_req) begin
          state_d = ST_LEAD;
          cmd_d   = shutdown_req ? CMD_SLEEP : CMD_READ;
          fcnt_d  = '0;
          cs_n_d  = 1'b0;
          woke_d  = awake_q;
        end
      end
      ST_LEAD, ST_LOW, ST_HIGH: begin
        if (abort) begin
          state_d = ST_QUIET;
          cs_n_d  = 1'b1;
          sclk_d  = 1'b1;
          if (fcnt_q >= EW'(SHDN_FIRST) && fcnt_q <= EW'(SHDN_LAST)) awake_d = 1'b0;
          else if (fcnt_q > EW'(SHDN_LAST))                          awake_d = 1'b1;
        end else if (div_done) begin
          if (state_q == ST_LEAD) begin
            state_d = ST_LOW;
            sclk_d  = 1'b0;
            fcnt_d  = fcnt_q + 1'b1;
          end else if (state_q == ST_LOW) begin
            if (cmd_q == CMD_SLEEP && fcnt_q == EW'(SLEEP_EDGE)) begin
              state_d = ST_QUIET;
              cs_n_d  = 1'b1;
              sclk_d  = 1'b1;
              awake_d = 1'b0;
            end else begin
              state_d = ST_HIGH;
              sclk_d  = 1'b1;
            end
          end else begin
            if (fcnt_q == EW'(FRAME_BITS)) begin
              state_d = ST_QUIET;
              cs_n_d  = 1'b1;
              awake_d = 1'b1;
              valid_d = woke_q;
              if (woke_q) sample_d = cap;
            end else begin
              state_d = ST_LOW;
              sclk_d  = 1'b0;
              fcnt_d  = fcnt_q + 1'b1;
            end
          end
        end
      end
      ST_QUIET: begin
        if (quiet_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_IDLE;
      cmd_q    <= CMD_READ;
      fcnt_q   <= '0;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b1;
      awake_q  <= 1'b0;
      woke_q   <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      state_q  <= state_d;
      cmd_q    <= cmd_d;
      fcnt_q   <= fcnt_d;
      cs_n_q   <= cs_n_d;
      sclk_q   <= sclk_d;
      awake_q  <= awake_d;
      woke_q   <= woke_d;
      valid_q  <= valid_d;
      sample_q <= sample_d;
    end
  end

  assign cs_n         = cs_n_q;
  assign sclk         = sclk_q;
  assign sample       = sample_q;
  assign sample_valid = valid_q;
  assign busy         = (state_q != ST_IDLE);
  assign awake        = awake_q;

  // quiet-gap observer for the assertion below
  localparam int HW = $clog2(QUIET_CYC + 2);
  logic [HW-1:0] hi_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                      hi_q <= HW'(QUIET_CYC);
    else if (!cs_n_q)                  hi_q <= '0;
    else if (hi_q < HW'(QUIET_CYC))    hi_q <= hi_q + 1'b1;
  end

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_i_n)
    cs_n_q |-> sclk_q); // R2
  AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(cs_n_q) |-> $past(hi_q) >= HW'(QUIET_CYC)); // R9
  AST_BUSY_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cs_n_q |-> busy); // R9
  AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_i_n)
    valid_q |-> ($rose(cs_n_q) && $past(fcnt_q) == EW'(FRAME_BITS) && $past(woke_q))); // R4
  AST_SLEEP_WINDOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(cs_n_q) && $past(fcnt_q) >= EW'(SHDN_FIRST) && $past(fcnt_q) <= EW'(SHDN_LAST))
      |-> !awake_q); // R8
  AST_EARLY_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(cs_n_q) && $past(fcnt_q) < EW'(SHDN_FIRST)) |-> (awake_q == $past(awake_q))); // R8
  AST_FULL_READ_WAKES: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(cs_n_q) && $past(fcnt_q) == EW'(FRAME_BITS)) |-> awake_q); // R5
endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int QC   = 5;
  localparam int FB   = 16;
  localparam int DB   = 12;

  logic clk = 1'b0;
  logic rst_n, start, shutdown_req, abort, miso;
  logic cs_n, sclk, sample_valid, busy, awake;
  logic [DB-1:0] sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_host_ctrl #(.CLK_DIV(DIV), .QUIET_CYC(QC), .FRAME_BITS(FB), .DATA_BITS(DB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .shutdown_req(shutdown_req), .abort(abort),
    .miso(miso), .cs_n(cs_n), .sclk(sclk), .sample(sample), .sample_valid(sample_valid),
    .busy(busy), .awake(awake));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural converter model
  logic [DB-1:0] cur_data = '0;
  int falls = 0, rises = 0;
  always @(negedge cs_n) begin falls = 0; rises = 0; end
  always @(negedge sclk) if (!cs_n) begin
    logic [FB-1:0] frame;
    frame = {{(FB-DB){1'b0}}, cur_data};
    falls = falls + 1;
    if (falls <= FB) miso = frame[FB-falls];
  end
  always @(posedge sclk) if (!cs_n) rises = rises + 1;

  // expectations (0 read, 1 sleep, 2 abort)
  int  exp_kind = 0, abort_at = 0;
  bit  model_awake = 1'b0;
  bit  mon_on = 1'b0;
  logic prev_cs = 1'b1;
  int  hi = 1000;

  function automatic bit awake_after_abort(input int f, input bit cur);
    if (f < 2)      return cur;
    else if (f <= 9) return 1'b0;
    else            return 1'b1;
  endfunction

  always @(negedge clk) if (mon_on) begin
    if (!cs_n && prev_cs) chk("R9 quiet gap before select", int'(hi >= QC), 1);
    if (!cs_n && !busy)   chk("R9 busy while selected", 0, 1);
    if (sample_valid && !(cs_n && !prev_cs)) chk("R4 strobe outside release", 1, 0);
    if (cs_n && !prev_cs) begin
      chk("R2 sclk high at release", sclk, 1);
      case (exp_kind)
        0: begin
          chk("R2 falling edges", falls, FB);
          chk("R2 rising edges", rises, FB);
          chk("R4 R5 valid strobe", sample_valid, model_awake);
          if (model_awake) chk("R3 captured sample", sample, cur_data);
          model_awake = 1'b1;
        end
        1: begin
          chk("R6 shutdown falling edges", falls, 3);
          chk("R6 no strobe", sample_valid, 0);
          model_awake = 1'b0;
        end
        default: begin
          chk("R8 edges before abort", falls, abort_at);
          chk("R8 no strobe", sample_valid, 0);
          model_awake = awake_after_abort(falls, model_awake);
        end
      endcase
      chk("R5 R6 R8 awake state", awake, model_awake);
    end
    if (cs_n) hi = hi + 1; else hi = 0;
    prev_cs = cs_n;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_release();
    while (!cs_n) @(negedge clk);
  endtask

  task automatic do_read(input logic [DB-1:0] d);
    wait_idle();
    cur_data = d; exp_kind = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_release();
  endtask

  task automatic do_sleep(input bit both);
    wait_idle();
    exp_kind = 1;
    shutdown_req = 1'b1; start = both; // R7 when both
    @(negedge clk); shutdown_req = 1'b0; start = 1'b0;
    wait_release();
  endtask

  task automatic do_abort(input int n);
    wait_idle();
    exp_kind = 2; abort_at = n; cur_data = DB'($urandom);
    start = 1'b1; @(negedge clk); start = 1'b0;
    while (!(falls == n && !cs_n)) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    wait_release();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; start = 1'b0; shutdown_req = 1'b0; abort = 1'b0; miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 1);
    chk("R1 busy", busy, 0);
    chk("R1 valid", sample_valid, 0);
    chk("R1 awake", awake, 0);
    mon_on = 1'b1;

    do_read(12'h123);   // R5 wake-up frame, data discarded
    do_read(12'hA5A);   // R3 R4
    do_read(12'hFFF);
    do_read(12'h000);
    do_sleep(1'b0);     // R6
    do_read(12'h7E1);   // R5
    do_read(12'h801);
    do_sleep(1'b1);     // R7
    do_read(12'h3C3);
    do_read(12'h5A5);
    foreach (abort_list[i]) do_abort(abort_list[i]); // R8 boundaries
    do_read(12'h111);

    // R10: requests while busy are dropped
    wait_idle();
    cur_data = 12'h9B6; exp_kind = 0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; shutdown_req = 1'b1; @(negedge clk); start = 1'b0; shutdown_req = 1'b0;
    wait_release();
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R10 no frame from busy requests", cs_n, 1);

    for (int k = 0; k < 60; k++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0, 1: do_read(DB'($urandom));
        2:    do_sleep(bit'($urandom % 2));
        default: do_abort(int'($urandom % 16));
      endcase
    end
    wait_idle();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int abort_list [8] = '{0, 1, 2, 9, 10, 15, 1, 12};
endmodule